// File: doc/BRIEF.md
# Serial Control-Port Register Slave

This block lets an external host read and program a bank of mode registers over a four-wire serial link. The link has a bit clock, an active-low frame enable, a data-in line and a data-out line. The data-out line comes with an output-enable, so the pad can be tri-stated. Every access is one 16-bit word sent most significant bit first. The top bit selects the direction, the next seven bits give the register index, and the low byte carries the data.

For a write, the byte is committed to the indexed register at the sixteenth clock of the frame. For a read, the indexed register is sent back on data-out during the second half of the same word, so the host needs only one word for the address and the answer.

All logic runs on the host's bit clock. It is independent of the system clock and of the audio interface. The frame enable acts as an asynchronous reset of the frame state, so raising it early abandons the word. A separate active-low reset sets the register bank to its default value. The full bank is also presented as a flat vector, which the rest of the chip decodes.

Top module: `spi_ctl_slave`

## Requirements
- R1: While rst_n is low, and after it is released, every register holds RESET_VAL (default 8'h00). Both regs_flat and serial reads show this value.
- R2: Data-in is sampled on rising sclk edges while cs_n is low, first bit first. Word bit 15 is the direction (0 = write, 1 = read), bits 14..8 are the register index, and bits 7..0 are the data. Register k occupies regs_flat[8k+7:8k].
- R3: A write frame changes the indexed register only at the sixteenth rising sclk edge of the frame. No other register changes.
- R4: In a read frame, sdo_oe rises at the falling edge after the eighth rising edge. sdo then carries the indexed register MSB first, changing on falling edges, so bit 7-j is valid at rising edge 9+j.
- R5: sdo_oe is low while cs_n is high, throughout write frames, and from the falling edge after the sixteenth rising edge onward. sdo is 0 whenever sdo_oe is low.
- R6: Raising cs_n before sixteen clocks aborts the frame. No register is updated, sdo_oe drops at once, and the next frame starts from bit 15.
- R7: Rising edges beyond the sixteenth within one frame are ignored. They cause no second write and no further driving of sdo.
- R8: A read frame leaves every register unchanged, whatever its low eight bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of the register bank |
| sclk | input | 1 | Serial bit clock from the host |
| cs_n | input | 1 | Active-low frame enable; high between words |
| mosi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Output-enable for the sdo pad |
| regs_flat | output | NREGS*DATA_W (1024) | Current contents of all registers, register k in bits 8k+7..8k |

## Verification
A wrong bit counter or header capture shows up in the very word where it happens. The enable window starts or ends off the ninth-to-sixteenth clock span, or the wrong register is driven out or written, and the bench sees this at the next rising edge. A corrupted or stray write in the bank appears on regs_flat right after the frame, because the whole bank is compared after every word. The next full readback sweep also exposes it. Aborted and overlong frames are followed at once by normal words, so any counter state left behind is caught in the next word.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

   typedef enum logic {
      DIR_WRITE = 1'b0,
      DIR_READ  = 1'b1
   } dir_e;

   function automatic int frame_bits(input int aw, input int dw);
      return 1 + aw + dw;
   endfunction

   function automatic int cnt_bits(input int aw, input int dw);
      return $clog2(frame_bits(aw, dw) + 1);
   endfunction

endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
   import spi_ctl_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   localparam int FRAME = frame_bits(ADDR_W, DATA_W),
   localparam int CNT_W = cnt_bits(ADDR_W, DATA_W)
) (
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              mosi,
   output logic [CNT_W-1:0]  cnt,
   output dir_e              dir,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data
);

   localparam int HEAD = 1 + ADDR_W;
   localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME);
   localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(FRAME - 1);
   localparam logic [CNT_W-1:0] HEAD_C  = CNT_W'(HEAD);

   logic [HEAD-1:0]   hdr_q;
   logic [DATA_W-2:0] dat_q;

   // bit counter, saturating at the frame length
   always_ff @(posedge sclk or posedge cs_n) begin
      if (cs_n) begin
         cnt <= '0;
      end else if (cnt != FRAME_C) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   // header capture: stops once the header is complete
   always_ff @(posedge sclk or posedge cs_n) begin
      if (cs_n) begin
         hdr_q <= '0;
      end else if (cnt < HEAD_C) begin
         hdr_q <= {hdr_q[HEAD-2:0], mosi};
      end
   end

   // data capture for all but the last data bit
   always_ff @(posedge sclk or posedge cs_n) begin
      if (cs_n) begin
         dat_q <= '0;
      end else if ((cnt >= HEAD_C) && (cnt < LAST_C)) begin
         dat_q <= {dat_q[DATA_W-3:0], mosi};
      end
   end

   assign dir     = dir_e'(hdr_q[HEAD-1]);
   assign addr    = hdr_q[ADDR_W-1:0];
   assign wr_data = {dat_q, mosi};
   assign wr_en   = !cs_n && (cnt == LAST_C) && (dir == DIR_WRITE);

   assert_cnt_bound_R7 : assert property (
      @(posedge sclk) disable iff (cs_n)
      cnt <= FRAME_C
   ) else $error("bit counter beyond frame length");

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int NREGS  = 2 ** ADDR_W,
   parameter logic [DATA_W-1:0] RESET_VAL = '0,
   localparam int FLAT_W = NREGS * DATA_W
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [FLAT_W-1:0] regs_flat
);

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge sclk or negedge rst_n) begin
         if (!rst_n) begin
            q <= RESET_VAL;
         end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
            q <= wr_data;
         end
      end
      assign regs_flat[g*DATA_W +: DATA_W] = q;
   end

   // indexes beyond the populated range read as zero
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREGS; i++) begin
         if (rd_addr == ADDR_W'(i)) begin
            rd_data = regs_flat[i*DATA_W +: DATA_W];
         end
      end
   end

endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx
   import spi_ctl_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   localparam int FRAME = frame_bits(ADDR_W, DATA_W),
   localparam int CNT_W = cnt_bits(ADDR_W, DATA_W)
) (
   input  logic              sclk,
   input  logic              cs_n,
   input  logic [CNT_W-1:0]  cnt,
   input  dir_e              dir,
   input  logic [DATA_W-1:0] rd_data,
   output logic              sdo,
   output logic              sdo_oe
);

   localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME);
   localparam logic [CNT_W-1:0] HEAD_C  = CNT_W'(1 + ADDR_W);

   logic [DATA_W-1:0] tx_q;
   logic              oe_q;

   // launch on falling edges so the host samples a settled bit
   always_ff @(negedge sclk or posedge cs_n) begin
      if (cs_n) begin
         oe_q <= 1'b0;
         tx_q <= '0;
      end else if ((cnt == HEAD_C) && (dir == DIR_READ)) begin
         oe_q <= 1'b1;
         tx_q <= rd_data;
      end else if (oe_q) begin
         if (cnt == FRAME_C) begin
            oe_q <= 1'b0;
            tx_q <= '0;
         end else begin
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
         end
      end
   end

   assign sdo_oe = oe_q;
   assign sdo    = oe_q & tx_q[DATA_W-1];

   assert_oe_read_R4 : assert property (
      @(negedge sclk) disable iff (cs_n)
      oe_q |-> (dir == DIR_READ)
   ) else $error("readback driven in a write frame");

   assert_oe_window_R5 : assert property (
      @(negedge sclk) disable iff (cs_n)
      oe_q |-> (cnt > HEAD_C)
   ) else $error("readback driven before the header completed");

endmodule

// File: rtl/spi_ctl_slave.sv
module spi_ctl_slave
   import spi_ctl_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int NREGS  = 2 ** ADDR_W,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic                    rst_n,
   input  logic                    sclk,
   input  logic                    cs_n,
   input  logic                    mosi,
   output logic                    sdo,
   output logic                    sdo_oe,
   output logic [NREGS*DATA_W-1:0] regs_flat
);

   localparam int CNT_W = cnt_bits(ADDR_W, DATA_W);

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("ADDR_W out of the supported range 1..10");
   end
   if (DATA_W < 3) begin : g_bad_data_w
      $error("DATA_W must be at least 3");
   end
   if (NREGS < 1 || NREGS > 2 ** ADDR_W) begin : g_bad_nregs
      $error("NREGS must lie between 1 and 2**ADDR_W");
   end

   logic [CNT_W-1:0]  cnt;
   dir_e              dir;
   logic [ADDR_W-1:0] addr;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_data;

   spi_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
      .sclk    (sclk),
      .cs_n    (cs_n),
      .mosi    (mosi),
      .cnt     (cnt),
      .dir     (dir),
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_data (wr_data)
   );

   spi_reg_bank #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS), .RESET_VAL(RESET_VAL)
   ) u_bank (
      .sclk      (sclk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (addr),
      .wr_data   (wr_data),
      .rd_addr   (addr),
      .rd_data   (rd_data),
      .regs_flat (regs_flat)
   );

   spi_rd_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
      .sclk    (sclk),
      .cs_n    (cs_n),
      .cnt     (cnt),
      .dir     (dir),
      .rd_data (rd_data),
      .sdo     (sdo),
      .sdo_oe  (sdo_oe)
   );

   assert_no_wr_during_rd_R3 : assert property (
      @(posedge sclk) disable iff (!rst_n || cs_n)
      wr_en |-> !sdo_oe
   ) else $error("register commit while readback is driven");

endmodule

// File: tb/spi_ctl_slave_test.sv
module spi_ctl_slave_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic mosi = 1'b0;
   logic sdo;
   logic sdo_oe;
   logic [1023:0] regs_flat;

   int vectors = 0;
   int miscompares = 0;
   logic [7:0] model [128];

   always #2.5 clk = ~clk;

   spi_ctl_slave uut (
      .rst_n     (rst_n),
      .sclk      (sclk),
      .cs_n      (cs_n),
      .mosi      (mosi),
      .sdo       (sdo),
      .sdo_oe    (sdo_oe),
      .regs_flat (regs_flat)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // compare the whole bank with the model; report the first mismatch
   task automatic chk_bank(input string tag);
      int bad_idx = -1;
      for (int k = 0; k < 128; k++) begin
         if (bad_idx < 0 && regs_flat[k*8 +: 8] !== model[k]) bad_idx = k;
      end
      if (bad_idx < 0) chk(1'b1, tag, 0, 0);
      else chk(1'b0, $sformatf("%s reg %0d", tag, bad_idx),
               {24'h0, regs_flat[bad_idx*8 +: 8]}, {24'h0, model[bad_idx]});
   endtask

   // one frame of nclk clocks; checks sdo_oe/sdo at every sample point
   task automatic frame(input logic [15:0] w, input int nclk, output logic [7:0] got);
      bit is_rd = w[15];
      bit exp_oe;
      int oe_bad = 0;
      got = 8'h00;
      cs_n = 1'b0;
      #2.5;
      for (int i = 0; i < nclk; i++) begin
         mosi = (i < 16) ? w[15-i] : ~w[i%16];
         #2.5;
         exp_oe = is_rd && (i >= 8) && (i <= 15);
         if (sdo_oe !== exp_oe) oe_bad++;
         if (!sdo_oe && sdo !== 1'b0) oe_bad++;
         if (i >= 8 && i <= 15) got[15-i] = sdo;
         sclk = 1'b1;
         #2.5;
         sclk = 1'b0;
      end
      #2.5;
      exp_oe = is_rd && (nclk >= 8) && (nclk <= 15);
      if (sdo_oe !== exp_oe) oe_bad++;
      chk(oe_bad == 0, $sformatf("R5 enable window (nclk=%0d rd=%0d)", nclk, is_rd),
          oe_bad, 0);
      cs_n = 1'b1;
      #1;
      chk(sdo_oe === 1'b0 && sdo === 1'b0, "R6 enable released on cs_n high",
          {30'h0, sdo_oe, sdo}, 0);
      #2;
   endtask

   task automatic do_write(input int a, input logic [7:0] d, input int nclk,
                           input string tag);
      logic [7:0] dummy;
      frame({1'b0, 7'(a), d}, nclk, dummy);
      if (nclk >= 16) model[a] = d;
      chk_bank(tag);
   endtask

   task automatic do_read(input int a, input logic [7:0] low, input int nclk,
                          input string tag);
      logic [7:0] got;
      frame({1'b1, 7'(a), low}, nclk, got);
      if (nclk >= 16)
         chk(got === model[a], $sformatf("%s R4 readback reg %0d", tag, a),
             {24'h0, got}, {24'h0, model[a]});
      chk_bank({tag, " R8 bank unchanged by read"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      for (int k = 0; k < 128; k++) model[k] = 8'h00;
      #12;
      // R1: bank at reset value while reset is held
      chk_bank("R1 bank during reset");
      rst_n = 1'b1;
      #8;
      chk_bank("R1 bank after reset release");
      do_read(0, 8'h00, 16, "R1");
      do_read(127, 8'h00, 16, "R1");
      do_read(64, 8'h00, 16, "R1");

      // R2/R3: write every register with an arithmetic pattern
      for (int k = 0; k < 128; k++)
         do_write(k, 8'((k * 37 + 11) & 255), 16, "R2 R3 write sweep");
      // R4/R8: read everything back, with a varying low byte in the read word
      for (int k = 0; k < 128; k++)
         do_read(k, 8'(255 - k), 16, "R4 sweep");

      // R3/R6: aborted writes commit nothing
      do_write(5, 8'h5A, 15, "R3 R6 abort at 15 clocks");
      do_write(6, 8'hC3, 8, "R6 abort at 8 clocks");
      do_write(7, 8'h81, 1, "R6 abort at 1 clock");
      // R6: aborted read, then a clean read and write right after
      do_read(5, 8'h00, 12, "R6 abort read at 12");
      do_read(5, 8'h00, 9, "R6 abort read at 9");
      do_read(5, 8'h00, 16, "R6 read after abort");
      do_write(6, 8'hC3, 16, "R6 write after abort");

      // R7: extra clocks ignored on write and on read
      do_write(9, 8'h3C, 20, "R7 write with 20 clocks");
      do_write(10, 8'h00, 24, "R7 write zero with 24 clocks");
      do_read(9, 8'hFF, 22, "R7 read with 22 clocks");
      do_read(10, 8'hAA, 16, "R7");

      // R8: read word with all-ones data leaves the register alone
      do_read(20, 8'hFF, 16, "R8");
      do_read(20, 8'h00, 16, "R8 repeat");

      // R1: second reset returns all registers to the reset value
      rst_n = 1'b0;
      #3;
      for (int k = 0; k < 128; k++) model[k] = 8'h00;
      chk_bank("R1 bank after second reset");
      rst_n = 1'b1;
      #3;
      do_read(9, 8'h00, 16, "R1 after second reset");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule